// File: doc/BRIEF.md
# Conditional Move Predicate Evaluator

This block decides whether a conditional floating-point move takes effect. For each request it receives the instruction word, the four two-bit floating-point comparison results, the 32-bit and 64-bit integer flag nibbles, and the value of one integer register. It returns a registered enable bit and a result strobe. When the enable is low, the move is to be treated as a no-op. The register-file read and the data transfer are done by other logic.

The block evaluates three kinds of predicate. The first tests one of the floating-point comparison fields. The second tests the integer flags, taken from either the 32-bit or the 64-bit set. The third compares a register value against zero. A two-bit family input selects which one applies. Each kind takes its test code and its invert bit from fixed instruction fields, and the result appears one clock after the request.

Top module: `cmov_pred_eval`

## Requirements
- R1: `valid_o` equals `valid_i` from the previous clock edge. `move_en_o` carries the predicate for that request and is 0 whenever `valid_o` is 0.
- R2: `family_i` selects the predicate kind: 0 is the floating-point condition, 1 is the integer flags, 2 is the register test and 3 is reserved. The reserved value always gives `move_en_o` = 0.
- R3: For the floating-point kind, `insn_i[12:11]` selects field n, which is `fcc_i[2n+1:2n]`. A field value of 0 means equal, 1 less, 2 greater and 3 unordered.
- R4: The floating-point test code is `insn_i[16:14]`. The codes are: 0 never; 1 field≠0; 2 field is 1 or 2; 3 field bit 0 set; 4 field=1; 5 field bit 1 set; 6 field=2; 7 field=3.
- R5: For the floating-point and integer kinds, `insn_i[17]` inverts the result of the test selected by `insn_i[16:14]`.
- R6: For the integer kind, the flags are read as N=bit 3, Z=bit 2, V=bit 1 and C=bit 0. `xcc_i` is used when `insn_i[12]` is 1 and `icc_i` when it is 0.
- R7: The integer test code is `insn_i[16:14]`. The codes are: 0 never; 1 Z; 2 Z or (N xor V); 3 N xor V; 4 C or Z; 5 C; 6 N; 7 V.
- R8: For the register kind, `insn_i[11:10]` selects the test: 1 is value==0, 2 is value≤0 signed and 3 is value<0 signed. `insn_i[12]` inverts the result. Codes 0 and 4 (`insn_i[11:10]`=0) are reserved and give 0.
- R9: For the register kind, a register index `insn_i[18:14]` of 0 makes the value read as zero, whatever `reg_val_i` holds.
- R10: While `rst_ni` is low, `valid_o` and `move_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| family_i | input | 2 | Predicate kind select |
| insn_i | input | 32 | Instruction word |
| fcc_i | input | 8 | Four floating-point condition fields, field n at bits 2n+1:2n |
| icc_i | input | 4 | 32-bit integer flags (N,Z,V,C) |
| xcc_i | input | 4 | 64-bit integer flags (N,Z,V,C) |
| reg_val_i | input | 64 | Register value for the zero tests |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| move_en_o | output | 1 | Move enable |

## Verification
Both outputs are due exactly one rising edge after a request is applied. The bench drives each request on a falling edge, waits for the next rising edge, and samples 1 ns after it, so it reads the registered result of that request and no other. The sweeps cover every selector, test code and invert bit. In each sweep the fields or flag sets that are not selected hold the complement of the selected one, so a wrong selection changes the observed enable.

// File: rtl/cmov_pkg.sv
package cmov_pkg;
  typedef enum logic [1:0] {
    FAM_FCC = 2'd0,
    FAM_ICC = 2'd1,
    FAM_RCC = 2'd2,
    FAM_RSV = 2'd3
  } family_e;

  localparam int unsigned INSN_W    = 32;
  localparam int unsigned CC_W      = 2;
  localparam int unsigned FLAG_W    = 4;
  localparam int unsigned TEST_LO   = 14;
  localparam int unsigned TEST_INV  = 17;
  localparam int unsigned FSEL_LO   = 11;
  localparam int unsigned XSEL_BIT  = 12;
  localparam int unsigned RIDX_LO   = 14;
  localparam int unsigned RIDX_W    = 5;
  localparam int unsigned RTEST_LO  = 10;
  localparam int unsigned RINV_BIT  = 12;
endpackage

// File: rtl/cmov_fcc_eval.sv
module cmov_fcc_eval
  import cmov_pkg::*;
#(
  parameter int unsigned NUM_FCC = 4
) (
  input  logic [INSN_W-1:0]       insn_i,
  input  logic [NUM_FCC*CC_W-1:0] fcc_i,
  output logic                    hit_o
);
  localparam int unsigned SEL_W = (NUM_FCC > 1) ? $clog2(NUM_FCC) : 1;

  logic [CC_W-1:0] fcc_arr [NUM_FCC];
  logic [SEL_W-1:0] sel;
  logic [CC_W-1:0]  f;
  logic [2:0]       test;
  logic             base;

  for (genvar n = 0; n < NUM_FCC; n++) begin : g_fld
    assign fcc_arr[n] = fcc_i[n*CC_W +: CC_W];
  end

  assign sel  = insn_i[FSEL_LO +: SEL_W];
  assign f    = fcc_arr[sel];
  assign test = insn_i[TEST_LO +: 3];

  always_comb begin
    unique case (test)
      3'd0: base = 1'b0;
      3'd1: base = (f != 2'd0);
      3'd2: base = (f == 2'd1) || (f == 2'd2);
      3'd3: base = f[0];
      3'd4: base = (f == 2'd1);
      3'd5: base = f[1];
      3'd6: base = (f == 2'd2);
      default: base = (f == 2'd3);
    endcase
  end

  assign hit_o = base ^ insn_i[TEST_INV];
endmodule

// File: rtl/cmov_icc_eval.sv
module cmov_icc_eval
  import cmov_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  input  logic [FLAG_W-1:0] icc_i,
  input  logic [FLAG_W-1:0] xcc_i,
  output logic              hit_o
);
  logic [FLAG_W-1:0] nib;
  logic n_f, z_f, v_f, c_f, lt;
  logic [2:0] test;
  logic base;

  assign nib  = insn_i[XSEL_BIT] ? xcc_i : icc_i;
  assign n_f  = nib[3];
  assign z_f  = nib[2];
  assign v_f  = nib[1];
  assign c_f  = nib[0];
  assign lt   = n_f ^ v_f;
  assign test = insn_i[TEST_LO +: 3];

  always_comb begin
    unique case (test)
      3'd0: base = 1'b0;
      3'd1: base = z_f;
      3'd2: base = z_f | lt;
      3'd3: base = lt;
      3'd4: base = c_f | z_f;
      3'd5: base = c_f;
      3'd6: base = n_f;
      default: base = v_f;
    endcase
  end

  assign hit_o = base ^ insn_i[TEST_INV];
endmodule

// File: rtl/cmov_rcc_eval.sv
module cmov_rcc_eval
  import cmov_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   reg_val_i,
  output logic              hit_o
);
  logic [XLEN-1:0] val;
  logic is_zero, is_neg, base;
  logic [1:0] test;

  // index 0 is the hardwired zero register
  assign val     = (insn_i[RIDX_LO +: RIDX_W] == '0) ? '0 : reg_val_i;
  assign is_zero = (val == '0);
  assign is_neg  = val[XLEN-1];
  assign test    = insn_i[RTEST_LO +: 2];

  always_comb begin
    unique case (test)
      2'd1: base = is_zero;
      2'd2: base = is_zero | is_neg;
      2'd3: base = is_neg;
      default: base = 1'b0;
    endcase
  end

  assign hit_o = (test == 2'd0) ? 1'b0 : (base ^ insn_i[RINV_BIT]);
endmodule

// File: rtl/cmov_pred_eval.sv
module cmov_pred_eval
  import cmov_pkg::*;
#(
  parameter int unsigned NUM_FCC = 4,
  parameter int unsigned XLEN    = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [1:0]              family_i,
  input  logic [INSN_W-1:0]       insn_i,
  input  logic [NUM_FCC*CC_W-1:0] fcc_i,
  input  logic [FLAG_W-1:0]       icc_i,
  input  logic [FLAG_W-1:0]       xcc_i,
  input  logic [XLEN-1:0]         reg_val_i,
  output logic                    valid_o,
  output logic                    move_en_o
);
  logic fcc_hit, icc_hit, rcc_hit, pred;
  family_e fam;

  assign fam = family_e'(family_i);

  cmov_fcc_eval #(.NUM_FCC(NUM_FCC)) u_fcc (
    .insn_i(insn_i), .fcc_i(fcc_i), .hit_o(fcc_hit)
  );

  cmov_icc_eval u_icc (
    .insn_i(insn_i), .icc_i(icc_i), .xcc_i(xcc_i), .hit_o(icc_hit)
  );

  cmov_rcc_eval #(.XLEN(XLEN)) u_rcc (
    .insn_i(insn_i), .reg_val_i(reg_val_i), .hit_o(rcc_hit)
  );

  always_comb begin
    unique case (fam)
      FAM_FCC: pred = fcc_hit;
      FAM_ICC: pred = icc_hit;
      FAM_RCC: pred = rcc_hit;
      default: pred = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      move_en_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      move_en_o <= valid_i & pred;
    end
  end
endmodule

// File: rtl/cmov_pred_eval_chk.sv
module cmov_pred_eval_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [1:0]  family_i,
  input logic [31:0] insn_i,
  input logic        valid_o,
  input logic        move_en_o
);
  a_r1_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r1_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r1_en_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    move_en_o |-> valid_o);
  a_r2_rsv_family: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && family_i == 2'd3) |=> !move_en_o);
  a_r5_fp_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && family_i == 2'd0 && insn_i[17:14] == 4'd8) |=> move_en_o);
  a_r7_int_never: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && family_i == 2'd1 && insn_i[17:14] == 4'd0) |=> !move_en_o);
  a_r8_reg_rsv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && family_i == 2'd2 && insn_i[11:10] == 2'd0) |=> !move_en_o);
  a_r9_reg_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && family_i == 2'd2 && insn_i[18:14] == 5'd0 && insn_i[12:10] == 3'd1)
    |=> move_en_o);
endmodule

bind cmov_pred_eval cmov_pred_eval_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .family_i(family_i),
  .insn_i(insn_i), .valid_o(valid_o), .move_en_o(move_en_o)
);

// File: tb/cmov_pred_eval_bench.sv
`timescale 1ns/1ps
module cmov_pred_eval_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  family_i = '0;
  logic [31:0] insn_i = '0;
  logic [7:0]  fcc_i = '0;
  logic [3:0]  icc_i = '0;
  logic [3:0]  xcc_i = '0;
  logic [63:0] reg_val_i = '0;
  logic        valid_o, move_en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  cmov_pred_eval u_cmov_pred_eval (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .family_i(family_i),
    .insn_i(insn_i), .fcc_i(fcc_i), .icc_i(icc_i), .xcc_i(xcc_i),
    .reg_val_i(reg_val_i), .valid_o(valid_o), .move_en_o(move_en_o)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic exp_fp(input logic [3:0] c, input logic [1:0] f);
    logic b;
    case (c[2:0])
      3'd0: b = 0;
      3'd1: b = (f != 0);
      3'd2: b = (f == 1) || (f == 2);
      3'd3: b = f[0];
      3'd4: b = (f == 1);
      3'd5: b = f[1];
      3'd6: b = (f == 2);
      default: b = (f == 3);
    endcase
    return b ^ c[3];
  endfunction

  function automatic logic exp_int(input logic [3:0] c, input logic [3:0] n);
    logic b;
    case (c[2:0])
      3'd0: b = 0;
      3'd1: b = n[2];
      3'd2: b = n[2] | (n[3] ^ n[1]);
      3'd3: b = n[3] ^ n[1];
      3'd4: b = n[0] | n[2];
      3'd5: b = n[0];
      3'd6: b = n[3];
      default: b = n[1];
    endcase
    return b ^ c[3];
  endfunction

  function automatic logic exp_reg(input logic [2:0] rc, input logic [63:0] v);
    logic b;
    case (rc[1:0])
      2'd0: return 1'b0;
      2'd1: b = (v == 0);
      2'd2: b = ($signed(v) <= 0);
      default: b = ($signed(v) < 0);
    endcase
    return b ^ rc[2];
  endfunction

  // one request, result sampled just after the next rising edge
  task automatic apply(input logic [1:0] fam, input logic [31:0] insn);
    @(negedge clk_i);
    valid_i  = 1'b1;
    family_i = fam;
    insn_i   = insn;
    @(posedge clk_i);
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk(valid_o, 1'b0, "R10 valid_o in reset");
    chk(move_en_o, 1'b0, "R10 move_en_o in reset");
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_fp_sweep();
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 16; c++)
        for (int f = 0; f < 4; f++) begin
          logic [31:0] w = '0;
          fcc_i = {4{2'(3 - f)}};
          fcc_i[2*s +: 2] = 2'(f);
          w[17:14] = 4'(c);
          w[12:11] = 2'(s);
          apply(2'd0, w);
          chk(valid_o, 1'b1, "R1 valid_o after request");
          chk(move_en_o, exp_fp(4'(c), 2'(f)), "R3/R4/R5 fp predicate");
        end
  endtask

  task automatic t_int_sweep();
    for (int x = 0; x < 2; x++)
      for (int c = 0; c < 16; c++)
        for (int n = 0; n < 16; n++) begin
          logic [31:0] w = '0;
          icc_i = x ? ~4'(n) : 4'(n);
          xcc_i = x ? 4'(n) : ~4'(n);
          w[17:14] = 4'(c);
          w[12]    = 1'(x);
          apply(2'd1, w);
          chk(move_en_o, exp_int(4'(c), 4'(n)), "R6/R7/R5 int predicate");
        end
  endtask

  task automatic t_reg();
    logic [63:0] vals [5] = '{64'd0, 64'd1, {64{1'b1}}, 64'h8000_0000_0000_0000,
                              64'h7fff_ffff_ffff_ffff};
    for (int rc = 0; rc < 8; rc++)
      for (int k = 0; k < 5; k++) begin
        logic [31:0] w = '0;
        reg_val_i = vals[k];
        w[18:14]  = 5'd9;
        w[12:10]  = 3'(rc);
        apply(2'd2, w);
        chk(move_en_o, exp_reg(3'(rc), vals[k]), "R8 register test");
      end
    for (int rc = 0; rc < 8; rc++) begin
      logic [31:0] w = '0;
      reg_val_i = 64'h8000_0000_0000_0005;
      w[12:10]  = 3'(rc);
      apply(2'd2, w);
      chk(move_en_o, exp_reg(3'(rc), 64'd0), "R9 index zero reads zero");
    end
  endtask

  task automatic t_reserved();
    logic [31:0] w = '0;
    w[17:14] = 4'd8;
    w[12:10] = 3'd5;
    fcc_i = 8'hff; icc_i = 4'hf; xcc_i = 4'hf;
    apply(2'd3, w);
    chk(valid_o, 1'b1, "R2 reserved family valid");
    chk(move_en_o, 1'b0, "R2 reserved family disables move");
  endtask

  task automatic t_idle();
    logic [31:0] w = '0;
    w[17:14] = 4'd8;
    apply(2'd0, w);
    chk(move_en_o, 1'b1, "R1 always-true request");
    @(negedge clk_i);
    valid_i = 1'b0;
    @(posedge clk_i);
    #1;
    chk(valid_o, 1'b0, "R1 valid_o low without request");
    chk(move_en_o, 1'b0, "R1 move_en_o low without request");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fp_sweep();
    t_int_sweep();
    t_reg();
    t_reserved();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule